// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Mode

This block buffers words between two clock domains that may be unrelated or identical. A producer on the write clock pushes words with a write enable and a consumer on the read clock pulls them with a read enable. Each transfer happens on the rising edge of its own port clock, and only while that port's enable is high. Read and write pointers cross between the domains as gray code with one extra wrap bit. Each pointer passes through a two-stage synchronizer before the opposite side uses it to build its flags.

The behaviour is chosen while the full reset is held and kept until the next full reset. In standard mode a word reaches `rd_data` only after an explicit read. In fall-through mode the oldest word is placed on `rd_data` without a read, in a one-word output stage that refills from memory whenever it is empty or being consumed. The two status flags change meaning with the mode. `out_flag` means empty in standard mode and output-ready in fall-through mode. `in_flag` means full in standard mode and input-ready in fall-through mode. Almost-empty and almost-full thresholds are captured from offset inputs during full reset.

A partial reset (`flush_n`) discards the contents but keeps the mode and both offsets. Both resets are synchronous and active low. They are sampled by both clocks and must be held for at least four cycles of the slower clock.

Top module: `dualclk_fwft_fifo`

## Requirements
- R1: The mode is taken from `mode_i` (0 = standard, 1 = fall-through) on every clock edge where `rst_n` is low. It then stays fixed until the next full reset, whatever `mode_i` does.
- R2: In standard mode an accepted write is stored but not shown. `rd_data` takes the oldest word on the read-clock edge that accepts a read (`rd_en` high while `out_flag` is low). Words leave in write order, and `rd_data` holds its value between accepted reads.
- R3: In fall-through mode the oldest word appears on `rd_data` with `out_flag` high and no read. While `out_flag` is high, `rd_en` consumes that word on the next read-clock edge and the following word (if any) takes its place.
- R4: `out_flag` is high when the FIFO holds no word in standard mode. In fall-through mode it is high when a valid word is on `rd_data`. After reset it reads 1 in standard mode and 0 in fall-through mode.
- R5: In standard mode `in_flag` is high when memory holds DEPTH words. In fall-through mode it is high while at least one memory location is free, so the FIFO then holds DEPTH+1 words counting the output stage.
- R6: `almost_empty` is high when the number of stored words, including a word held in the fall-through output stage, is at or below the captured empty offset.
- R7: `almost_full` is high when the number of words in memory (not counting the output stage) exceeds DEPTH minus the captured full offset.
- R8: A write while the FIFO is full (standard) or not input-ready (fall-through) is ignored. The word is not stored and no stored word is overwritten.
- R9: A read while empty (standard) or not output-ready (fall-through) is ignored. `rd_data` keeps its value and the read position does not move.
- R10: Holding `flush_n` low empties the FIFO and returns the flags to their empty state. The captured mode and offsets are kept, and the offset inputs have no effect during the flush.
- R11: During full reset both offsets are captured from `ae_ofs_i` and `af_ofs_i` (range 0 to DEPTH), `rd_data` is cleared to zero and all flags take their empty state.
- R12: Pointers cross domains as gray code that changes by at most one bit per clock. Under concurrent traffic on both clocks, every accepted word is delivered once, intact and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Full reset, synchronous, active low, sampled by both clocks |
| flush_n | input | 1 | Partial reset that empties the FIFO, synchronous, active low |
| mode_i | input | 1 | Mode select captured during full reset: 0 standard, 1 fall-through |
| ae_ofs_i | input | ADDR_W+1 | Almost-empty offset captured during full reset |
| af_ofs_i | input | ADDR_W+1 | Almost-full offset captured during full reset |
| wr_en | input | 1 | Write enable |
| wr_data | input | DATA_W | Write data |
| in_flag | output | 1 | Full (standard) or input-ready (fall-through), write-clock domain |
| almost_full | output | 1 | Almost-full flag, write-clock domain |
| rd_en | input | 1 | Read enable |
| rd_data | output | DATA_W | Read data |
| out_flag | output | 1 | Empty (standard) or output-ready (fall-through), read-clock domain |
| almost_empty | output | 1 | Almost-empty flag, read-clock domain |

## Verification
The embedded assertions check the following on every cycle: a blocked write or read leaves its pointer still, the write-side occupancy never exceeds DEPTH, each gray pointer flips at most one bit per edge, a presented fall-through word stays put until consumed, and the captured mode does not drift. Only the bench scenarios can show the rest. These are the data order across the two unrelated clocks, the exact flag thresholds on both sides of each offset, the extra word of capacity in fall-through mode, that a refused write leaves no trace in the read-out stream, and that a flush keeps mode and offsets while new offset inputs are applied.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the dual-clock FIFO: the mode encoding and the
// binary/gray conversions used by both pointer domains.
// Assumes pointer widths of at most 32 bits.
package dcf_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

    // Binary to reflected gray code.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected gray code back to binary.
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a gray-coded pointer entering a clock domain.
// Assumes the source changes at most one bit between destination samples.
// clr_n clears every stage synchronously.
module dcf_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] chain;

    // Shift the sampled pointer through the stage chain.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[LAST];

endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
// Simple dual-port storage: synchronous write on the write clock,
// combinational read by address. Assumes the reader only addresses
// locations whose write is already visible through the synchronized pointer.
module dcf_ram #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store one word per accepted write.
    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
// Write-domain control: write pointer in binary and gray, the full /
// input-ready flag and the almost-full flag. Captures mode and full offset
// during full reset. Assumes rgray_s is already synchronized to wr_clk.
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          wr_clk,
    input  logic          rst_n,
    input  logic          flush_n,
    input  logic          mode_i,
    input  logic [AW:0]   af_ofs_i,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_s,
    output logic [AW-1:0] waddr,
    output logic          wr_take,
    output logic [AW:0]   wgray,
    output logic          in_flag,
    output logic          almost_full
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    fifo_mode_e    mode_q;
    logic [PW-1:0] af_ofs_q;
    logic [PW-1:0] wbin_q;
    logic [PW-1:0] wbin_d;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] occ_d;
    logic [PW-1:0] af_thr;
    logic          full_q;
    logic          afull_q;
    logic          clear;

    assign clear = !rst_n || !flush_n;

    // Capture configuration while full reset is held.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            mode_q   <= fifo_mode_e'(mode_i);
            af_ofs_q <= af_ofs_i;
        end
    end

    // Next pointer and occupancy as seen after this edge.
    always_comb begin
        rbin_s  = PW'(from_gray(32'(rgray_s)));
        wr_take = wr_en && !full_q;
        wbin_d  = wbin_q + PW'(wr_take);
        occ_d   = wbin_d - rbin_s;
        af_thr  = DEPTH_P - af_ofs_q;
    end

    // Pointer and flag registers of the write domain.
    always_ff @(posedge wr_clk) begin
        if (clear) begin
            wbin_q  <= '0;
            wgray   <= '0;
            full_q  <= 1'b0;
            afull_q <= 1'b0;
        end else begin
            wbin_q  <= wbin_d;
            wgray   <= PW'(to_gray(32'(wbin_d)));
            full_q  <= (occ_d == DEPTH_P);
            afull_q <= (occ_d > af_thr);
        end
    end

    assign waddr       = wbin_q[AW-1:0];
    assign in_flag     = (mode_q == MODE_FWFT) ? !full_q : full_q;
    assign almost_full = afull_q;

    // R8: a write refused while full must not move the pointer.
    p_no_overflow_r8: assert property (@(posedge wr_clk) disable iff (clear)
        (full_q && wr_en) |=> $stable(wbin_q));

    // R5: write-side occupancy never exceeds the memory depth.
    p_occ_bound_r5: assert property (@(posedge wr_clk) disable iff (clear)
        ((wbin_q - rbin_s) <= DEPTH_P));

    // R12: the exported gray pointer flips at most one bit per edge.
    p_wgray_step_r12: assert property (@(posedge wr_clk) disable iff (clear)
        $onehot0(wgray ^ $past(wgray)));

    // R1: captured mode stays fixed outside full reset.
    p_wmode_hold_r1: assert property (@(posedge wr_clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_q));

endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
// Read-domain control: read pointer, output register / fall-through stage,
// the empty / output-ready flag and the almost-empty flag. Captures mode and
// empty offset during full reset. Assumes wgray_s is synchronized to rd_clk.
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          flush_n,
    input  logic          mode_i,
    input  logic [AW:0]   ae_ofs_i,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] mem_q,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] rd_data,
    output logic          out_flag,
    output logic          almost_empty
);
    localparam int PW = AW + 1;

    fifo_mode_e    mode_q;
    logic [PW-1:0] ae_ofs_q;
    logic [PW-1:0] rbin_q;
    logic [PW-1:0] rbin_d;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] occ_d;
    logic          mempty_q;
    logic          stage_q;
    logic          stage_d;
    logic          take;
    logic          ae_q;
    logic          clear;

    assign clear = !rst_n || !flush_n;

    // Capture configuration while full reset is held.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            mode_q   <= fifo_mode_e'(mode_i);
            ae_ofs_q <= ae_ofs_i;
        end
    end

    // Decide whether a word leaves memory and what the stage holds next.
    always_comb begin
        wbin_s = PW'(from_gray(32'(wgray_s)));
        if (mode_q == MODE_FWFT) begin
            take    = !mempty_q && (!stage_q || rd_en);
            stage_d = take ? 1'b1 : (rd_en ? 1'b0 : stage_q);
        end else begin
            take    = rd_en && !mempty_q;
            stage_d = 1'b0;
        end
        rbin_d = rbin_q + PW'(take);
        occ_d  = (wbin_s - rbin_d) + PW'(stage_d);
    end

    // Pointer, stage and flag registers of the read domain.
    always_ff @(posedge rd_clk) begin
        if (clear) begin
            rbin_q   <= '0;
            rgray    <= '0;
            mempty_q <= 1'b1;
            stage_q  <= 1'b0;
            ae_q     <= 1'b1;
        end else begin
            rbin_q   <= rbin_d;
            rgray    <= PW'(to_gray(32'(rbin_d)));
            mempty_q <= (wbin_s == rbin_d);
            stage_q  <= stage_d;
            ae_q     <= (occ_d <= ae_ofs_q);
        end
    end

    // Output data register, loaded whenever a word leaves memory.
    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (flush_n && take) begin
            rd_data <= mem_q;
        end
    end

    assign raddr        = rbin_q[AW-1:0];
    assign out_flag     = (mode_q == MODE_FWFT) ? stage_q : mempty_q;
    assign almost_empty = ae_q;

    // R9: a standard-mode read while empty leaves the pointer still.
    p_no_underflow_r9: assert property (@(posedge rd_clk) disable iff (clear)
        (mode_q == MODE_STD && mempty_q && rd_en) |=> $stable(rbin_q));

    // R9: without a read, standard-mode output data holds.
    p_std_hold_r9: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (mode_q == MODE_STD && !rd_en) |=> $stable(rd_data));

    // R3: a presented fall-through word stays until it is consumed.
    p_fwft_hold_r3: assert property (@(posedge rd_clk) disable iff (clear)
        (mode_q == MODE_FWFT && stage_q && !rd_en) |=> (stage_q && $stable(rd_data)));

    // R12: the exported gray pointer flips at most one bit per edge.
    p_rgray_step_r12: assert property (@(posedge rd_clk) disable iff (clear)
        $onehot0(rgray ^ $past(rgray)));

    // R1: captured mode stays fixed outside full reset.
    p_rmode_hold_r1: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_q));

endmodule

// File: rtl/dualclk_fwft_fifo.sv
`timescale 1ns/1ps
// Dual-clock FIFO top: storage, write-domain and read-domain control, and
// the two pointer synchronizers. Assumes both resets are held for at least
// four cycles of the slower clock so that both domains see them together.
module dualclk_fwft_fifo #(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              flush_n,
    input  logic              mode_i,
    input  logic [ADDR_W:0]   ae_ofs_i,
    input  logic [ADDR_W:0]   af_ofs_i,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              in_flag,
    output logic              almost_full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              out_flag,
    output logic              almost_empty
);
    localparam int PW = ADDR_W + 1;

    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic              wr_take;
    logic [PW-1:0]     wgray;
    logic [PW-1:0]     rgray;
    logic [PW-1:0]     wgray_s;
    logic [PW-1:0]     rgray_s;
    logic [DATA_W-1:0] mem_q;
    logic              clr_n;

    assign clr_n = rst_n && flush_n;

    dcf_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
        .wr_clk (wr_clk),
        .we     (wr_take),
        .waddr  (waddr),
        .wdata  (wr_data),
        .raddr  (raddr),
        .rdata  (mem_q)
    );

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk   (wr_clk),
        .clr_n (clr_n),
        .d     (rgray),
        .q     (rgray_s)
    );

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk   (rd_clk),
        .clr_n (clr_n),
        .d     (wgray),
        .q     (wgray_s)
    );

    dcf_wr_side #(.AW(ADDR_W)) u_wr (
        .wr_clk      (wr_clk),
        .rst_n       (rst_n),
        .flush_n     (flush_n),
        .mode_i      (mode_i),
        .af_ofs_i    (af_ofs_i),
        .wr_en       (wr_en),
        .rgray_s     (rgray_s),
        .waddr       (waddr),
        .wr_take     (wr_take),
        .wgray       (wgray),
        .in_flag     (in_flag),
        .almost_full (almost_full)
    );

    dcf_rd_side #(.DW(DATA_W), .AW(ADDR_W)) u_rd (
        .rd_clk       (rd_clk),
        .rst_n        (rst_n),
        .flush_n      (flush_n),
        .mode_i       (mode_i),
        .ae_ofs_i     (ae_ofs_i),
        .rd_en        (rd_en),
        .wgray_s      (wgray_s),
        .mem_q        (mem_q),
        .raddr        (raddr),
        .rgray        (rgray),
        .rd_data      (rd_data),
        .out_flag     (out_flag),
        .almost_empty (almost_empty)
    );

endmodule

// File: tb/sim_dualclk_fwft_fifo.sv
`timescale 1ns/1ps
module sim_dualclk_fwft_fifo;
    localparam int DW    = 32;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush_n = 1'b1;
    logic          mode_i = 1'b0;
    logic [AW:0]   ae_ofs = 9'd8;
    logic [AW:0]   af_ofs = 9'd16;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          in_flag;
    logic          almost_full;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          out_flag;
    logic          almost_empty;

    always #2   wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    dualclk_fwft_fifo #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .flush_n(flush_n),
        .mode_i(mode_i), .ae_ofs_i(ae_ofs), .af_ofs_i(af_ofs),
        .wr_en(wr_en), .wr_data(wr_data), .in_flag(in_flag), .almost_full(almost_full),
        .rd_en(rd_en), .rd_data(rd_data), .out_flag(out_flag), .almost_empty(almost_empty)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    bit          mode_m = 1'b0;
    logic [31:0] q[$];
    bit          pend = 1'b0;
    logic [31:0] pend_val;
    logic [31:0] saved;

    task automatic chk_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit wready();
        return mode_m ? (in_flag == 1'b1) : (in_flag == 1'b0);
    endfunction

    task automatic settle();
        repeat (10) @(negedge rd_clk);
    endtask

    task automatic full_reset(input bit m, input int ae, input int af);
        rst_n  = 1'b0;
        mode_i = m;
        ae_ofs = 9'(ae);
        af_ofs = 9'(af);
        repeat (6) @(negedge rd_clk);
        rst_n  = 1'b1;
        mode_m = m;
        q.delete();
        pend = 1'b0;
        settle();
    endtask

    // Write exactly n words, each only while the FIFO reports room.
    task automatic wr_words(input int n);
        int got = 0;
        while (got < n) begin
            @(negedge wr_clk);
            if (wready()) begin
                wr_en   = 1'b1;
                wr_data = $urandom;
                q.push_back(wr_data);
                got++;
            end else begin
                wr_en = 1'b0;
            end
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    // One write attempt regardless of readiness.
    task automatic wr_force(input logic [31:0] d);
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_data = d;
        if (wready()) q.push_back(d);
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_rand(input int n, input int prob);
        repeat (n) begin
            @(negedge wr_clk);
            wr_en   = ($urandom_range(99) < prob);
            wr_data = $urandom;
            if (wr_en && wready()) q.push_back(wr_data);
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    // One read-side step at a rd_clk negedge: check, then drive rd_en.
    task automatic rd_step(input int prob, input string tag);
        if (pend) begin
            chk_eq({tag, " read data"}, rd_data, pend_val);
            pend = 1'b0;
        end
        if (mode_m && out_flag) begin
            if (q.size() == 0) chk_eq({tag, " head with model empty"}, 1, 0);
            else chk_eq({tag, " head word"}, rd_data, q[0]);
        end
        rd_en = ($urandom_range(99) < prob);
        if (rd_en) begin
            if (!mode_m && !out_flag) begin
                if (q.size() == 0) chk_eq({tag, " read with model empty"}, 1, 0);
                else begin
                    pend = 1'b1;
                    pend_val = q.pop_front();
                end
            end else if (mode_m && out_flag && q.size() > 0) begin
                void'(q.pop_front());
            end
        end
    endtask

    task automatic rd_finish(input string tag);
        @(negedge rd_clk);
        if (pend) begin
            chk_eq({tag, " read data"}, rd_data, pend_val);
            pend = 1'b0;
        end
        rd_en = 1'b0;
    endtask

    task automatic rd_run(input int n, input int prob, input string tag);
        repeat (n) begin
            @(negedge rd_clk);
            rd_step(prob, tag);
        end
        rd_finish(tag);
    endtask

    task automatic drain(input string tag);
        int guard = 0;
        while (q.size() > 0 && guard < 5000) begin
            @(negedge rd_clk);
            rd_step(100, tag);
            guard++;
        end
        rd_finish(tag);
        chk_eq({tag, " drain completed"}, q.size(), 0);
        settle();
    endtask

    initial begin
        #700000;
        n_bad++;
        $display("FAIL watchdog (R12): got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // Standard mode, AE offset 8, AF offset 16.
        full_reset(1'b0, 8, 16);
        chk_eq("R4 R11 reset out_flag std", out_flag, 1);
        chk_eq("R5 R11 reset in_flag std", in_flag, 0);
        chk_eq("R6 R11 reset almost_empty", almost_empty, 1);
        chk_eq("R7 R11 reset almost_full", almost_full, 0);
        chk_eq("R11 reset rd_data", rd_data, 0);

        wr_words(1);
        settle();
        chk_eq("R2 no data before read", rd_data, 0);
        chk_eq("R4 std not empty", out_flag, 0);
        rd_run(1, 100, "R2");
        settle();
        chk_eq("R4 std empty again", out_flag, 1);

        wr_words(8);
        settle();
        chk_eq("R6 AE at offset", almost_empty, 1);
        wr_words(1);
        settle();
        chk_eq("R6 AE above offset", almost_empty, 0);
        drain("R2");

        wr_words(240);
        settle();
        chk_eq("R7 AF at threshold", almost_full, 0);
        chk_eq("R5 not full at 240", in_flag, 0);
        wr_words(1);
        settle();
        chk_eq("R7 AF above threshold", almost_full, 1);
        wr_words(DEPTH - 241);
        settle();
        chk_eq("R5 std full", in_flag, 1);
        wr_force(32'hDEADBEEF);
        drain("R8");
        chk_eq("R8 empty after drain", out_flag, 1);

        saved = rd_data;
        rd_run(4, 100, "R9");
        chk_eq("R9 rd_data held on empty read", rd_data, saved);
        settle();
        chk_eq("R9 still empty", out_flag, 1);
        wr_words(1);
        settle();
        rd_run(1, 100, "R9");

        fork
            wr_rand(2000, 60);
            rd_run(1400, 55, "R2 R12");
        join
        drain("R2 R12");

        // Fall-through mode, AE offset 4, AF offset 8.
        full_reset(1'b1, 4, 8);
        chk_eq("R1 R4 reset out_flag fwft", out_flag, 0);
        chk_eq("R5 R11 reset in_flag fwft", in_flag, 1);
        chk_eq("R6 R11 reset almost_empty fwft", almost_empty, 1);
        chk_eq("R7 R11 reset almost_full fwft", almost_full, 0);

        wr_words(1);
        settle();
        chk_eq("R3 head shown without read", rd_data, q[0]);
        chk_eq("R3 R4 output ready", out_flag, 1);
        wr_words(3);
        settle();
        chk_eq("R6 fwft AE with stage word", almost_empty, 1);
        wr_words(1);
        settle();
        chk_eq("R6 fwft AE above offset", almost_empty, 0);
        chk_eq("R3 head unchanged without read", rd_data, q[0]);

        mode_i = 1'b0;
        ae_ofs = 9'd20;
        af_ofs = 9'd100;
        flush_n = 1'b0;
        repeat (6) @(negedge rd_clk);
        flush_n = 1'b1;
        q.delete();
        settle();
        chk_eq("R10 flushed out_flag keeps fwft meaning", out_flag, 0);
        chk_eq("R10 flushed in_flag ready", in_flag, 1);
        chk_eq("R10 flushed almost_empty", almost_empty, 1);
        wr_words(5);
        settle();
        chk_eq("R10 AE offset kept", almost_empty, 0);
        chk_eq("R1 R10 mode kept, head shown", rd_data, q[0]);
        chk_eq("R10 output ready after flush", out_flag, 1);
        drain("R3");

        wr_words(DEPTH + 1);
        settle();
        chk_eq("R5 fwft not ready at DEPTH+1", in_flag, 0);
        chk_eq("R7 fwft AF", almost_full, 1);
        wr_force(32'hCAFEF00D);
        drain("R8");
        chk_eq("R4 fwft not ready when empty", out_flag, 0);
        saved = rd_data;
        rd_run(4, 100, "R9");
        chk_eq("R9 fwft rd_data held", rd_data, saved);
        chk_eq("R9 fwft still not ready", out_flag, 0);

        fork
            wr_rand(2000, 55);
            rd_run(1400, 60, "R3 R12");
        join
        drain("R3 R12");

        full_reset(1'b0, 8, 16);
        chk_eq("R1 new mode after full reset", out_flag, 1);
        chk_eq("R1 std in_flag after full reset", in_flag, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule